// File: doc/BRIEF.md
# Nine-bit multiprocessor serial port

This block is an asynchronous serial port with independent transmit and receive paths, paced by an external enable that pulses at sixteen times the bit rate. It carries either an eight-bit character or a nine-bit character. In the nine-bit form the extra bit tells an address frame (1) from a data frame (0). A host reaches the block through a one-bit register address: a control/status byte and a buffer. A write to the buffer starts a transmission. A read of the buffer returns the separate receive holding register.

For multi-drop links the control byte holds a filter enable. While the filter is set in nine-bit operation, only frames whose ninth bit is 1 are stored and flagged, so every node sees address frames and ignores data frames. Software that recognises its own address clears the filter and then takes the data frames that follow. In eight-bit operation the same filter bit instead rejects any frame whose stop bit was sampled low.

Top module: `ninebit_mp_uart`

## Requirements
- R1: After reset the control byte (address 0) and the buffer (address 1) both read 0x00, the serial output is high and the interrupt output is low.
- R2: The control byte layout is: bits 7:6 the frame mode, bit 5 the filter enable, bit 4 the receive enable, bit 3 the transmit ninth bit, bit 2 the received ninth bit (read-only), bit 1 the transmit-done flag and bit 0 the receive-done flag. Mode bit 7 = 1 selects nine-bit frames. Otherwise frames have eight data bits.
- R3: A write to address 1 loads the transmitter and starts a frame on the serial output: a low start bit, then the eight data bits least significant first, then (in nine-bit mode only) the transmit ninth bit, then a high stop bit. Each bit lasts 16 baud ticks.
- R4: The transmit-done flag becomes 1 at the start of the stop bit. It stays 1 until software writes 0 to control bit 1.
- R5: A read of address 1 returns the receive holding register, never the byte being transmitted.
- R6: With the filter clear, every completed reception stores the data (least significant bit first on the line) in the receive holding register and sets the receive-done flag. The received ninth bit takes the ninth data bit in nine-bit mode and the sampled stop bit in eight-bit mode.
- R7: With the filter set in nine-bit mode, a frame whose ninth bit is 0 leaves the receive holding register, the received ninth bit and the receive-done flag unchanged. A frame whose ninth bit is 1 is accepted.
- R8: With the filter set in eight-bit mode, a frame whose stop bit is sampled low is rejected in the same way, and a frame with a high stop bit is accepted.
- R9: A start bit is confirmed only if the line is still low at the 8th tick after the falling edge. A shorter low pulse returns the receiver to idle and stores nothing.
- R10: While the receive enable is 0, incoming frames are ignored.
- R11: The interrupt output is high whenever the transmit-done or the receive-done flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control byte, 1 = buffer |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default 16x oversampling and an eight-bit data width, and it pulses the baud tick every second clock, so one bit spans 32 cycles. At that rate the bench can sample the serial output at mid-bit and read the flags inside the last data bit and inside the stop bit, which places the transmit-done edge exactly. The same rate makes a three-tick glitch short enough to fail the mid-start check. The vector table covers both frame lengths, the filter on and off, and both stop-bit levels.

// File: rtl/mpser_pkg.sv
package mpser_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} phase_e;
  localparam int C_RXDONE = 0;
  localparam int C_TXDONE = 1;
  localparam int C_RX9    = 2;
  localparam int C_TX9    = 3;
  localparam int C_RXEN   = 4;
  localparam int C_FILT   = 5;
  localparam int C_MODE9  = 7;
endpackage

// File: rtl/mpser_tx.sv
module mpser_tx
  import mpser_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic          nine,
  input  logic [DW-1:0] din,
  input  logic          bit9,
  output logic          txd,
  output logic          stop_pulse
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 1);

  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [DW:0]   sr_q, sr_n;
  logic          nine_q, nine_n;
  logic          bit_end, last_bit;

  assign bit_end  = tick && (cnt_q == CW'(OVS - 1));
  assign last_bit = nine_q ? (idx_q == IW'(DW)) : (idx_q == IW'(DW - 1));
  assign stop_pulse = (ph_q == PH_DATA) && bit_end && last_bit;

  always_comb begin
    ph_n = ph_q; cnt_n = cnt_q; idx_n = idx_q; sr_n = sr_q; nine_n = nine_q;
    if (load) begin
      ph_n = PH_START; cnt_n = '0; idx_n = '0; sr_n = {bit9, din}; nine_n = nine;
    end else if (tick && ph_q != PH_IDLE) begin
      if (bit_end) begin
        cnt_n = '0;
        case (ph_q)
          PH_START: ph_n = PH_DATA;
          PH_DATA: begin
            sr_n = sr_q >> 1;
            if (last_bit) ph_n = PH_STOP;
            else          idx_n = idx_q + 1'b1;
          end
          default: ph_n = PH_IDLE;
        endcase
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0; sr_q <= '0; nine_q <= 1'b0;
    end else begin
      ph_q <= ph_n; cnt_q <= cnt_n; idx_q <= idx_n; sr_q <= sr_n; nine_q <= nine_n;
    end
  end

  always_comb begin
    case (ph_q)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sr_q[0];
      default:  txd = 1'b1;
    endcase
  end

  assert_load_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !load) |=> txd);
endmodule

// File: rtl/mpser_rx.sv
module mpser_rx
  import mpser_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd_raw,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          bit9
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 1);

  logic          s1_q, s2_q;
  phase_e        ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [DW:0]   sr_q, sr_n;
  logic          nine_q, nine_n;
  logic          bit_end, mid_start, last_bit;

  assign bit_end   = tick && (cnt_q == CW'(OVS - 1));
  assign mid_start = tick && (cnt_q == CW'(OVS / 2 - 1));
  assign last_bit  = nine_q ? (idx_q == IW'(DW)) : (idx_q == IW'(DW - 1));

  always_comb begin
    ph_n = ph_q; cnt_n = cnt_q; idx_n = idx_q; sr_n = sr_q; nine_n = nine_q;
    case (ph_q)
      PH_IDLE:
        if (tick && en && !s2_q) begin
          ph_n = PH_START; cnt_n = '0; nine_n = nine;
        end
      PH_START:
        if (mid_start) begin
          cnt_n = '0; idx_n = '0;
          ph_n  = s2_q ? PH_IDLE : PH_DATA;
        end else if (tick) begin
          cnt_n = cnt_q + 1'b1;
        end
      PH_DATA:
        if (bit_end) begin
          cnt_n = '0;
          sr_n  = {s2_q, sr_q[DW:1]};
          if (last_bit) ph_n = PH_STOP;
          else          idx_n = idx_q + 1'b1;
        end else if (tick) begin
          cnt_n = cnt_q + 1'b1;
        end
      default:
        if (bit_end) begin
          cnt_n = '0; ph_n = PH_IDLE;
        end else if (tick) begin
          cnt_n = cnt_q + 1'b1;
        end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1; s2_q <= 1'b1;
      ph_q <= PH_IDLE; cnt_q <= '0; idx_q <= '0; sr_q <= '0; nine_q <= 1'b0;
    end else begin
      s1_q <= rxd_raw; s2_q <= s1_q;
      ph_q <= ph_n; cnt_q <= cnt_n; idx_q <= idx_n; sr_q <= sr_n; nine_q <= nine_n;
    end
  end

  assign valid = (ph_q == PH_STOP) && bit_end;
  assign data  = nine_q ? sr_q[DW-1:0] : sr_q[DW:1];
  assign bit9  = nine_q ? sr_q[DW] : s2_q;

  assert_false_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_START && mid_start && s2_q) |=> (ph_q == PH_IDLE));
  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !en) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/ninebit_mp_uart.sv
module ninebit_mp_uart
  import mpser_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txd,
  input  logic              rxd,
  output logic              irq
);
  logic [1:0]        mode_q, mode_n;
  logic              filt_q, filt_n, rxen_q, rxen_n, tx9_q, tx9_n;
  logic              rx9_q, rx9_n, txdone_q, txdone_n, rxdone_q, rxdone_n;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_n;
  logic              ctrl_wr, buf_wr, tx_stop, rx_valid, rx_bit9, accept;
  logic [DATA_W-1:0] rx_data;

  assign ctrl_wr = bus_wr && !bus_addr;
  assign buf_wr  = bus_wr && bus_addr;

  mpser_tx #(.OVS(OVS), .DW(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(buf_wr),
    .nine(mode_q[1]), .din(bus_wdata), .bit9(tx9_q),
    .txd(txd), .stop_pulse(tx_stop));

  mpser_rx #(.OVS(OVS), .DW(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .en(rxen_q),
    .nine(mode_q[1]), .rxd_raw(rxd),
    .valid(rx_valid), .data(rx_data), .bit9(rx_bit9));

  assign accept = rx_valid && (!filt_q || rx_bit9);

  always_comb begin
    mode_n = mode_q; filt_n = filt_q; rxen_n = rxen_q; tx9_n = tx9_q;
    rx9_n = rx9_q; txdone_n = txdone_q; rxdone_n = rxdone_q; rxbuf_n = rxbuf_q;
    if (ctrl_wr) begin
      mode_n   = bus_wdata[C_MODE9:C_MODE9-1];
      filt_n   = bus_wdata[C_FILT];
      rxen_n   = bus_wdata[C_RXEN];
      tx9_n    = bus_wdata[C_TX9];
      txdone_n = bus_wdata[C_TXDONE];
      rxdone_n = bus_wdata[C_RXDONE];
    end
    if (tx_stop) txdone_n = 1'b1;
    if (accept) begin
      rxdone_n = 1'b1; rxbuf_n = rx_data; rx9_n = rx_bit9;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; filt_q <= 1'b0; rxen_q <= 1'b0; tx9_q <= 1'b0;
      rx9_q <= 1'b0; txdone_q <= 1'b0; rxdone_q <= 1'b0; rxbuf_q <= '0;
    end else begin
      mode_q <= mode_n; filt_q <= filt_n; rxen_q <= rxen_n; tx9_q <= tx9_n;
      rx9_q <= rx9_n; txdone_q <= txdone_n; rxdone_q <= rxdone_n; rxbuf_q <= rxbuf_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) begin
      bus_rdata = rxbuf_q;
    end else begin
      bus_rdata[C_MODE9:C_MODE9-1] = mode_q;
      bus_rdata[C_FILT]   = filt_q;
      bus_rdata[C_RXEN]   = rxen_q;
      bus_rdata[C_TX9]    = tx9_q;
      bus_rdata[C_RX9]    = rx9_q;
      bus_rdata[C_TXDONE] = txdone_q;
      bus_rdata[C_RXDONE] = rxdone_q;
    end
  end

  assign irq = txdone_q | rxdone_q;

  assert_txdone_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stop |=> txdone_q);
  // R8 shares this check: in eight-bit mode rx_bit9 is the sampled stop bit
  assert_reject_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && filt_q && !rx_bit9) |=> ($stable(rxbuf_q) && $stable(rx9_q)));
  assert_filter_nine_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rxdone_q) && !$past(ctrl_wr) && $past(filt_q) && $past(mode_q[1])) |-> rx9_q);
endmodule

// File: tb/sim_ninebit_mp_uart.sv
module sim_ninebit_mp_uart;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BITC       = 16 * TICK_DIV;
  // vector: {nine, filt, data[7:0], bit9, stop}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 8'h3C, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'hC3, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h5A, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h12, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h77, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'hE4, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'hFF, 1'b1, 1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic txd, irq, rxd = 1'b1;
  int n_chk = 0, n_fail = 0, tdiv = 0;
  bit finished = 0;
  logic [7:0] last_buf, v;

  ninebit_mp_uart u0 (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rxd), .irq(irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    baud_tick = (tdiv == TICK_DIV - 1);
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic send(input logic nine, input logic [7:0] d, input logic b9, input logic stp);
    @(negedge clk); rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; repeat (BITC) @(negedge clk);
    end
    if (nine) begin rxd = b9; repeat (BITC) @(negedge clk); end
    rxd = stp; repeat (BITC) @(negedge clk);
    rxd = 1'b1; repeat (2 * BITC) @(negedge clk);
  endtask

  task automatic tx_frame(input logic nine, input logic [7:0] d, input logic b9);
    logic [7:0] r;
    int nb;
    nb = nine ? 9 : 8;
    wr(1'b1, d);
    while (txd) @(negedge clk);
    repeat (BITC / 2) @(negedge clk);
    check(txd == 1'b0, "R3 start bit", txd, 0);
    for (int i = 0; i < nb; i++) begin
      repeat (BITC) @(negedge clk);
      check(txd == ((i < 8) ? d[i] : b9), "R3 data bit", txd, (i < 8) ? d[i] : b9);
      if (i == 3) begin
        peek(1'b1, r);
        check(r == last_buf, "R5 buffer read during transmit", r, last_buf);
      end
      if (i == nb - 1) begin
        peek(1'b0, r);
        check(r[1] == 1'b0, "R4 tx done clear before stop", r[1], 0);
      end
    end
    repeat (BITC) @(negedge clk);
    check(txd == 1'b1, "R3 stop bit", txd, 1);
    peek(1'b0, r);
    check(r[1] == 1'b1, "R4 tx done at stop", r[1], 1);
    repeat (BITC) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    peek(1'b0, v); check(v == 8'h00, "R1 control reset", v, 0);
    peek(1'b1, v); check(v == 8'h00, "R1 buffer reset", v, 0);
    check(txd == 1'b1 && irq == 1'b0, "R1 txd/irq reset", {txd, irq}, 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    last_buf = 8'h00;

    // R2 layout: write all writable bits, read back (rx9 read-only stays 0)
    wr(1'b0, 8'hFC);
    peek(1'b0, v); check(v == 8'hF8, "R2 control layout", v, 8'hF8);

    wr(1'b0, 8'b1000_1000);            // nine-bit, tx ninth = 1
    tx_frame(1'b1, 8'hA5, 1'b1);
    check(irq == 1'b1, "R11 irq from tx done", irq, 1);
    wr(1'b0, 8'b0100_0000);            // eight-bit, tx ninth 0, clear flags
    peek(1'b0, v); check(v[1] == 1'b0 && irq == 1'b0, "R4 tx done cleared by write", v, 8'h40);
    tx_frame(1'b0, 8'h3B, 1'b0);
    wr(1'b0, 8'b0100_0000);

    for (int k = 0; k < 8; k++) begin
      logic nine, filt, b9, stp, acc, exp9;
      logic [7:0] d;
      {nine, filt, d, b9, stp} = VEC[k];
      acc  = !filt || (nine ? b9 : stp);
      exp9 = nine ? b9 : stp;
      wr(1'b0, {nine ? 2'b10 : 2'b01, filt, 1'b1, 4'b0000});
      send(nine, d, b9, stp);
      peek(1'b0, v);
      check(v[0] == acc, filt ? (nine ? "R7 filter done flag" : "R8 filter done flag")
                              : "R6 done flag", v[0], acc);
      if (acc) begin
        check(v[2] == exp9, "R6 received ninth bit", v[2], exp9);
        last_buf = d;
      end else begin
        check(v[2] == u0_prev9(k), nine ? "R7 ninth bit held" : "R8 ninth bit held", v[2], u0_prev9(k));
      end
      peek(1'b1, v);
      check(v == last_buf, acc ? "R6 buffer data" : "R7 R8 buffer held", v, last_buf);
      check(irq == acc, "R11 irq from rx done", irq, acc);
    end

    // R9 glitch shorter than half a bit
    wr(1'b0, 8'b1001_0000);
    @(negedge clk); rxd = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITC) @(negedge clk);
    peek(1'b0, v); check(v[0] == 1'b0, "R9 glitch ignored", v[0], 0);
    peek(1'b1, v); check(v == last_buf, "R9 buffer after glitch", v, last_buf);
    send(1'b1, 8'h69, 1'b0, 1'b1);
    peek(1'b1, v); check(v == 8'h69, "R9 frame after glitch", v, 8'h69);
    last_buf = 8'h69;

    // R10 receiver disabled
    wr(1'b0, 8'b1000_0000);
    send(1'b1, 8'h0F, 1'b1, 1'b1);
    peek(1'b0, v); check(v[0] == 1'b0, "R10 disabled done flag", v[0], 0);
    peek(1'b1, v); check(v == last_buf, "R10 disabled buffer", v, last_buf);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // expected received ninth bit before vector k: ninth bit of the last accepted vector
  function automatic logic u0_prev9(input int k);
    logic r;
    r = 1'b0;
    for (int j = 0; j < k; j++) begin
      logic nn, ff, bb, ss;
      logic [7:0] dd;
      {nn, ff, dd, bb, ss} = VEC[j];
      if (!ff || (nn ? bb : ss)) r = nn ? bb : ss;
    end
    return r;
  endfunction
endmodule